// File: doc/BRIEF.md
# Load/Store Unit with Atomic Sequencer

This block is the memory access unit of a single-issue 32-bit core. The execute stage presents one operation at a time: an operation code, an effective address and a store operand. The unit checks alignment, drives a single-port data memory, and returns a sign- or zero-extended load result. Every access starts and finishes while the operation sits in the execute stage. While a multi-cycle access is in flight the unit raises a stall, and the requester holds its inputs steady.

Read-modify-write atomics run as an uninterruptible sequence. The unit reads the word, combines it with the register operand, writes the result, and returns the original word. No other access can enter between the read and the write. That is enough for atomicity because only one core shares the memory, so no bus lock or coherence traffic is needed. Load-reserved and store-conditional use a single reservation held inside the unit.

The state machine has four states. **IDLE** accepts an operation. **READ** consumes returned read data. **WRITE** stores the atomic result. **DONE** reports the atomic result. The transitions are:
- IDLE→READ: an aligned load, load-reserved or atomic is accepted.
- IDLE→IDLE: a store, a store-conditional, a misaligned access or an unknown code completes at once.
- READ→IDLE: a load or load-reserved completes, or an atomic is aborted by a fault.
- READ→WRITE: an atomic read returns without a fault.
- WRITE→DONE: the atomic result is stored.
- DONE→IDLE: the atomic result is reported.

Top module: `ldst_unit`

## Requirements
- R1: After reset, `stall_o`, `done_o` and `mem_req_o` are low while no request is presented, and no reservation is held, so a first store-conditional fails.
- R2: A misaligned access completes in its request cycle with `misaligned_o`=1, `done_o`=1, result 0 and no memory request. An access is misaligned when a halfword has address bit 0 set, or when a word, load-reserved, store-conditional or atomic has address bits [1:0] non-zero.
- R3: A load requests the word at the address with bits [1:0] cleared, with stall high and `mem_we_o`=0, in its request cycle. It completes in the next cycle with no request in that cycle.
- R4: A store completes in its request cycle without stall. Byte enable bit i covers data bits [8i+7:8i]. A byte store enables lane addr[1:0]. A halfword store enables lanes addr[1]*2 and addr[1]*2+1. A word store enables all four. The operand's low byte or halfword is replicated across lanes so that each enabled lane carries the right byte.
- R5: Byte and halfword loads pick the lanes selected by the address and extend them to 32 bits: with the sign bit for the signed codes and with zeros for the unsigned codes.
- R6: An atomic reads in its request cycle (stall high), makes no request in the next cycle, writes the whole word in the cycle after (stall high), and completes in the fourth cycle with the original word as the result.
- R7: The atomic write value is the operand for swap, and the sum, XOR, AND or OR of the memory word and operand for those codes. For the minimum and maximum codes it is the smaller or larger of the two, compared as signed numbers for the signed codes and as unsigned numbers for the unsigned codes.
- R8: A fault-free load-reserved records its word address. A following store-conditional to the same word writes the operand as a full word, returns 0 and completes in its request cycle.
- R9: A store-conditional without a matching reservation returns 1 and makes no memory request. Every store-conditional, whether it succeeds, fails or is misaligned, clears the reservation.
- R10: `mem_fault_i` is sampled in the cycle that read data returns. A faulted load or load-reserved completes with `fault_o`=1 and result 0, and a faulted load-reserved sets no reservation. A faulted atomic completes in that same cycle with `fault_o`=1 and result 0, and it never issues its write.
- R11: The operation codes are: 0 signed byte load, 1 signed halfword load, 2 word load, 3 unsigned byte load, 4 unsigned halfword load, 5 byte store, 6 halfword store, 7 word store, 8 load-reserved, 9 store-conditional, 10 swap, 11 add, 12 XOR, 13 AND, 14 OR, 15 signed min, 16 signed max, 17 unsigned min, 18 unsigned max. Codes 19 to 31 complete in the request cycle with result 0 and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Operation presented; held until `done_o` |
| req_op_i | input | 5 | Operation code (R11) |
| req_addr_i | input | 32 | Effective byte address |
| req_wdata_i | input | 32 | Store or atomic operand |
| stall_o | output | 1 | Pipeline hold while an access is in flight |
| done_o | output | 1 | Operation completes this cycle |
| result_o | output | 32 | Destination register value, valid with `done_o` |
| misaligned_o | output | 1 | Misaligned exception, valid with `done_o` |
| fault_o | output | 1 | Access fault, valid with `done_o` |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word-aligned memory address |
| mem_be_o | output | 4 | Write byte enables |
| mem_wdata_o | output | 32 | Write data, lane-placed |
| mem_rdata_i | input | 32 | Read data, one cycle after the request |
| mem_fault_i | input | 1 | Access fault, with the read data |

## Verification
The hardest case to reach is an atomic aborted between its read and its write. The fault must arrive in exactly the cycle the read data returns, and the check must show that no write follows. The bench memory model raises the fault for one chosen word. It then runs an atomic, a load and a load-reserved against that word and confirms that the stored word has not changed. A store-conditional follows to show that no reservation was left behind. Reservation clearing by a mismatched or misaligned store-conditional is reached with load-reserved and store-conditional pairs aimed at different words.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
    localparam int XLEN  = 32;
    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);
    localparam int OPC_W = 5;

    typedef enum logic [OPC_W-1:0] {
        OP_LB    = 5'd0,
        OP_LH    = 5'd1,
        OP_LW    = 5'd2,
        OP_LBU   = 5'd3,
        OP_LHU   = 5'd4,
        OP_SB    = 5'd5,
        OP_SH    = 5'd6,
        OP_SW    = 5'd7,
        OP_LR    = 5'd8,
        OP_SC    = 5'd9,
        OP_ASWAP = 5'd10,
        OP_AADD  = 5'd11,
        OP_AXOR  = 5'd12,
        OP_AAND  = 5'd13,
        OP_AOR   = 5'd14,
        OP_AMIN  = 5'd15,
        OP_AMAX  = 5'd16,
        OP_AMINU = 5'd17,
        OP_AMAXU = 5'd18
    } ldst_op_e;

    typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} acc_size_e;

    typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE} ldst_state_e;

    function automatic logic op_known(input logic [OPC_W-1:0] op);
        return op <= OP_AMAXU;
    endfunction

    function automatic logic op_is_amo(input logic [OPC_W-1:0] op);
        return (op >= OP_ASWAP) && (op <= OP_AMAXU);
    endfunction

    function automatic logic op_is_read(input logic [OPC_W-1:0] op);
        return (op <= OP_LHU) || (op == OP_LR) || op_is_amo(op);
    endfunction

    function automatic logic op_is_store(input logic [OPC_W-1:0] op);
        return (op >= OP_SB) && (op <= OP_SW);
    endfunction

    function automatic logic op_unsigned(input logic [OPC_W-1:0] op);
        return (op == OP_LBU) || (op == OP_LHU);
    endfunction

    function automatic acc_size_e op_size(input logic [OPC_W-1:0] op);
        acc_size_e s;
        if (op == OP_LB || op == OP_LBU || op == OP_SB)      s = SZ_BYTE;
        else if (op == OP_LH || op == OP_LHU || op == OP_SH) s = SZ_HALF;
        else                                                 s = SZ_WORD;
        return s;
    endfunction
endpackage

// File: rtl/ldst_align.sv
module ldst_align
    import ldst_pkg::*;
(
    input  acc_size_e              size_i,
    input  logic [OFF_W-1:0]       off_i,
    input  logic [XLEN-1:0]        data_i,
    output logic [LANES-1:0]       be_o,
    output logic [XLEN-1:0]        lane_data_o,
    output logic                   misaligned_o
);
    assign misaligned_o = ((size_i == SZ_HALF) && off_i[0]) ||
                          ((size_i == SZ_WORD) && (off_i != '0));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX = OFF_W'(g);
        logic hit_byte;
        logic hit_half;
        assign hit_byte = (off_i == LANE_IDX);
        assign hit_half = (off_i[OFF_W-1:1] == LANE_IDX[OFF_W-1:1]);
        assign be_o[g]  = (size_i == SZ_WORD) ||
                          ((size_i == SZ_HALF) && hit_half) ||
                          ((size_i == SZ_BYTE) && hit_byte);
        assign lane_data_o[8*g +: 8] =
            (size_i == SZ_WORD) ? data_i[8*g +: 8] :
            (size_i == SZ_HALF) ? data_i[8*(g%2) +: 8] :
                                  data_i[7:0];
    end
endmodule

// File: rtl/ldst_extend.sv
module ldst_extend
    import ldst_pkg::*;
(
    input  logic [XLEN-1:0]  word_i,
    input  logic [OFF_W-1:0] off_i,
    input  acc_size_e        size_i,
    input  logic             unsigned_i,
    output logic [XLEN-1:0]  value_o
);
    logic [XLEN-1:0] shifted;
    logic            sgn;

    assign shifted = word_i >> {off_i, 3'b000};

    always_comb begin
        sgn = 1'b0;
        case (size_i)
            SZ_BYTE: begin
                sgn     = ~unsigned_i & shifted[7];
                value_o = {{(XLEN-8){sgn}}, shifted[7:0]};
            end
            SZ_HALF: begin
                sgn     = ~unsigned_i & shifted[15];
                value_o = {{(XLEN-16){sgn}}, shifted[15:0]};
            end
            default: value_o = shifted;
        endcase
    end
endmodule

// File: rtl/ldst_amo_alu.sv
module ldst_amo_alu
    import ldst_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    input  logic [XLEN-1:0]  mem_i,
    input  logic [XLEN-1:0]  reg_i,
    output logic [XLEN-1:0]  new_o
);
    logic lt_signed;
    logic lt_unsigned;

    assign lt_signed   = $signed(mem_i) < $signed(reg_i);
    assign lt_unsigned = mem_i < reg_i;

    always_comb begin
        case (op_i)
            OP_AADD:  new_o = mem_i + reg_i;
            OP_AXOR:  new_o = mem_i ^ reg_i;
            OP_AAND:  new_o = mem_i & reg_i;
            OP_AOR:   new_o = mem_i | reg_i;
            OP_AMIN:  new_o = lt_signed   ? mem_i : reg_i;
            OP_AMAX:  new_o = lt_signed   ? reg_i : mem_i;
            OP_AMINU: new_o = lt_unsigned ? mem_i : reg_i;
            OP_AMAXU: new_o = lt_unsigned ? reg_i : mem_i;
            default:  new_o = reg_i;
        endcase
    end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [OPC_W-1:0]  req_op_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [XLEN-1:0]   req_wdata_i,
    output logic              stall_o,
    output logic              done_o,
    output logic [XLEN-1:0]   result_o,
    output logic              misaligned_o,
    output logic              fault_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [LANES-1:0]  mem_be_o,
    output logic [XLEN-1:0]   mem_wdata_o,
    input  logic [XLEN-1:0]   mem_rdata_i,
    input  logic              mem_fault_i
);
    localparam int WADDR_W = ADDR_W - OFF_W;

    ldst_state_e        state_q, state_d;
    logic [OPC_W-1:0]   op_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [XLEN-1:0]    wdata_q;
    logic [XLEN-1:0]    load_q;
    logic               resv_valid_q;
    logic [WADDR_W-1:0] resv_addr_q;

    logic [LANES-1:0]   al_be;
    logic [XLEN-1:0]    al_data;
    logic               al_mis;
    logic               req_known;
    logic               req_misaligned;
    logic               sc_match;
    logic [XLEN-1:0]    ext_value;
    logic [XLEN-1:0]    amo_value;
    logic [ADDR_W-1:0]  req_word_addr;
    logic [ADDR_W-1:0]  held_word_addr;

    ldst_align u_align (
        .size_i       (op_size(req_op_i)),
        .off_i        (req_addr_i[OFF_W-1:0]),
        .data_i       (req_wdata_i),
        .be_o         (al_be),
        .lane_data_o  (al_data),
        .misaligned_o (al_mis)
    );

    ldst_extend u_extend (
        .word_i     (mem_rdata_i),
        .off_i      (addr_q[OFF_W-1:0]),
        .size_i     (op_size(op_q)),
        .unsigned_i (op_unsigned(op_q)),
        .value_o    (ext_value)
    );

    ldst_amo_alu u_amo (
        .op_i  (op_q),
        .mem_i (load_q),
        .reg_i (wdata_q),
        .new_o (amo_value)
    );

    assign req_known      = op_known(req_op_i);
    assign req_misaligned = req_known && al_mis;
    assign sc_match       = resv_valid_q && (resv_addr_q == req_addr_i[ADDR_W-1:OFF_W]);
    assign req_word_addr  = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign held_word_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i && req_known && !req_misaligned && op_is_read(req_op_i))
                    state_d = ST_READ;
            end
            ST_READ: begin
                if (op_is_amo(op_q) && !mem_fault_i) state_d = ST_WRITE;
                else                                 state_d = ST_IDLE;
            end
            ST_WRITE: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        stall_o      = 1'b0;
        done_o       = 1'b0;
        result_o     = '0;
        misaligned_o = 1'b0;
        fault_o      = 1'b0;
        mem_req_o    = 1'b0;
        mem_we_o     = 1'b0;
        mem_addr_o   = '0;
        mem_be_o     = '0;
        mem_wdata_o  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid_i) begin
                    if (!req_known) begin
                        done_o = 1'b1;
                    end else if (req_misaligned) begin
                        done_o       = 1'b1;
                        misaligned_o = 1'b1;
                    end else if (op_is_read(req_op_i)) begin
                        stall_o    = 1'b1;
                        mem_req_o  = 1'b1;
                        mem_addr_o = req_word_addr;
                        mem_be_o   = al_be;
                    end else if (op_is_store(req_op_i)) begin
                        done_o      = 1'b1;
                        mem_req_o   = 1'b1;
                        mem_we_o    = 1'b1;
                        mem_addr_o  = req_word_addr;
                        mem_be_o    = al_be;
                        mem_wdata_o = al_data;
                    end else begin
                        done_o   = 1'b1;
                        result_o = sc_match ? '0 : XLEN'(1);
                        if (sc_match) begin
                            mem_req_o   = 1'b1;
                            mem_we_o    = 1'b1;
                            mem_addr_o  = req_word_addr;
                            mem_be_o    = '1;
                            mem_wdata_o = req_wdata_i;
                        end
                    end
                end
            end
            ST_READ: begin
                if (op_is_amo(op_q)) begin
                    if (mem_fault_i) begin
                        done_o  = 1'b1;
                        fault_o = 1'b1;
                    end else begin
                        stall_o = 1'b1;
                    end
                end else begin
                    done_o   = 1'b1;
                    fault_o  = mem_fault_i;
                    result_o = mem_fault_i ? '0 : ext_value;
                end
            end
            ST_WRITE: begin
                stall_o     = 1'b1;
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = held_word_addr;
                mem_be_o    = '1;
                mem_wdata_o = amo_value;
            end
            ST_DONE: begin
                done_o   = 1'b1;
                result_o = load_q;
            end
        endcase
    end

    // Operation capture and atomic read value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            load_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && req_valid_i) begin
                op_q    <= req_op_i;
                addr_q  <= req_addr_i;
                wdata_q <= req_wdata_i;
            end
            if (state_q == ST_READ) load_q <= mem_rdata_i;
        end
    end

    // Reservation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resv_valid_q <= 1'b0;
            resv_addr_q  <= '0;
        end else if (state_q == ST_IDLE && req_valid_i && req_op_i == OP_SC) begin
            resv_valid_q <= 1'b0;
        end else if (state_q == ST_READ && op_q == OP_LR && !mem_fault_i) begin
            resv_valid_q <= 1'b1;
            resv_addr_q  <= addr_q[ADDR_W-1:OFF_W];
        end
    end
endmodule

// File: rtl/ldst_checker.sv
module ldst_checker
    import ldst_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OPC_W-1:0] req_op_i,
    input logic             stall_o,
    input logic             done_o,
    input logic [XLEN-1:0]  result_o,
    input logic             misaligned_o,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [LANES-1:0] mem_be_o
);
    // R2: a misaligned access completes and touches no memory
    p_misalign_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned_o |-> (done_o && !mem_req_o));

    // R3: the cycle after a read request carries no request
    p_read_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> !mem_req_o);

    // R6: an atomic write follows a request-free cycle and keeps the stall
    p_amo_write_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && !done_o) |-> ($past(!mem_req_o) && stall_o));

    // R4: writes enable one, two or four lanes
    p_store_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o) |->
            ($countones(mem_be_o) == 1 || $countones(mem_be_o) == 2 ||
             $countones(mem_be_o) == 4));

    // R9: a failing store-conditional makes no request
    p_sc_fail_nostore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && req_op_i == OP_SC && result_o == XLEN'(1)) |-> !mem_req_o);
endmodule

bind ldst_unit ldst_checker u_ldst_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_op_i     (req_op_i),
    .stall_o      (stall_o),
    .done_o       (done_o),
    .result_o     (result_o),
    .misaligned_o (misaligned_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_be_o     (mem_be_o)
);

// File: tb/ldst_unit_tb_top.sv
module ldst_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [4:0]  req_op;
    logic [31:0] req_addr;
    logic [31:0] req_wdata;
    logic        stall, done, mis, flt;
    logic [31:0] result;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic [31:0] rd_q;
    logic        rf_q;

    int checks = 0;
    int errors = 0;
    int fault_idx = -1;
    logic [31:0] mem  [64];
    logic [31:0] rmem [64];
    bit          ref_resv;
    logic [29:0] ref_resv_addr;

    always #2 clk = ~clk;

    ldst_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .stall_o(stall), .done_o(done), .result_o(result), .misaligned_o(mis), .fault_o(flt),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(rd_q), .mem_fault_i(rf_q)
    );

    // Memory model: writes at the edge, read data and fault one cycle later
    always @(posedge clk) begin
        if (mem_req && mem_we)
            for (int l = 0; l < 4; l++)
                if (mem_be[l]) mem[mem_addr[7:2]][8*l +: 8] <= mem_wdata[8*l +: 8];
        if (mem_req && !mem_we) begin
            rd_q <= mem[mem_addr[7:2]];
            rf_q <= (int'(mem_addr[7:2]) == fault_idx);
        end else begin
            rf_q <= 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] amo_ref(input int op, input logic [31:0] a, input logic [31:0] b);
        case (op)
            10: return b;
            11: return a + b;
            12: return a ^ b;
            13: return a & b;
            14: return a | b;
            15: return ($signed(a) < $signed(b)) ? a : b;
            16: return ($signed(a) > $signed(b)) ? a : b;
            17: return (a < b) ? a : b;
            default: return (a > b) ? a : b;
        endcase
    endfunction

    // Reference model and per-cycle comparison of one operation
    task automatic do_op(input int op, input logic [31:0] addr, input logic [31:0] wd, input string tag);
        int          idx = int'(addr[7:2]);
        int          off = int'(addr[1:0]);
        int          sz;
        int          lat = 0;
        bit [3:0]    reqmask = '0;
        logic [31:0] old = rmem[idx];
        logic [31:0] exp_res = '0;
        logic [31:0] sh;
        bit          exp_mis = 0, exp_flt = 0;
        bit          known = (op <= 18);
        bit          isread = (op <= 4) || (op == 8) || (op >= 10 && op <= 18);
        if (op == 0 || op == 3 || op == 5)      sz = 1;
        else if (op == 1 || op == 4 || op == 6) sz = 2;
        else                                    sz = 4;
        if (!known) begin
            exp_res = '0;
        end else if (off % sz != 0) begin
            exp_mis = 1;
            if (op == 9) ref_resv = 0;
        end else if (isread) begin
            reqmask[0] = 1'b1;
            if (op >= 10) begin
                if (idx == fault_idx) begin
                    lat = 1; exp_flt = 1;
                end else begin
                    lat = 3; reqmask[2] = 1'b1; exp_res = old;
                    rmem[idx] = amo_ref(op, old, wd);
                end
            end else begin
                lat = 1;
                if (idx == fault_idx) exp_flt = 1;
                else begin
                    sh = old >> (8 * off);
                    if (sz == 1)      exp_res = (op == 3) ? {24'h0, sh[7:0]}  : {{24{sh[7]}}, sh[7:0]};
                    else if (sz == 2) exp_res = (op == 4) ? {16'h0, sh[15:0]} : {{16{sh[15]}}, sh[15:0]};
                    else              exp_res = old;
                    if (op == 8) begin ref_resv = 1; ref_resv_addr = addr[31:2]; end
                end
            end
        end else if (op >= 5 && op <= 7) begin
            reqmask[0] = 1'b1;
            for (int b = 0; b < sz; b++) rmem[idx][8*(off+b) +: 8] = wd[8*b +: 8];
        end else begin
            if (ref_resv && ref_resv_addr == addr[31:2]) begin
                reqmask[0] = 1'b1; rmem[idx] = wd; exp_res = '0;
            end else begin
                exp_res = 32'd1;
            end
            ref_resv = 0;
        end

        @(negedge clk);
        req_valid = 1'b1; req_op = op[4:0]; req_addr = addr; req_wdata = wd;
        for (int k = 0; k <= lat; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            chk({tag, " stall"}, {31'b0, stall}, {31'b0, k < lat});
            chk({tag, " done"}, {31'b0, done}, {31'b0, k == lat});
            chk({tag, " mem_req"}, {31'b0, mem_req}, {31'b0, reqmask[k]});
            if (reqmask[k] && mem_req) chk({tag, " mem_addr"}, mem_addr, {addr[31:2], 2'b00});
            if (k == lat) begin
                chk({tag, " result"}, result, exp_res);
                chk({tag, " misaligned"}, {31'b0, mis}, {31'b0, exp_mis});
                chk({tag, " fault"}, {31'b0, flt}, {31'b0, exp_flt});
            end
        end
        @(posedge clk);
        #1;
        chk({tag, " memory word"}, mem[idx], rmem[idx]);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        summary();
        $finish;
    end

    localparam logic [31:0] B = 32'h0000_1000;

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]  = 32'h9E37_79B9 * 32'(i + 1);
            rmem[i] = 32'h9E37_79B9 * 32'(i + 1);
        end
        rd_q = '0; rf_q = 1'b0;
        ref_resv = 0; ref_resv_addr = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 reset stall", {31'b0, stall}, 32'd0);
        chk("R1 reset done", {31'b0, done}, 32'd0);
        chk("R1 reset mem_req", {31'b0, mem_req}, 32'd0);
        rst_n = 1'b1;

        do_op(9, B + 32'd0, 32'h1111_1111, "R1 sc after reset");

        // Stores and lane placement
        do_op(7, B + 32'd8, 32'h8081_7F01, "R4 sw");
        for (int o = 0; o < 4; o++) do_op(5, B + 32'd12 + 32'(o), 32'h0000_00A0 + 32'(o), "R4 sb lane");
        do_op(6, B + 32'd16, 32'h1234_BEEF, "R4 sh low");
        do_op(6, B + 32'd18, 32'h5678_8001, "R4 sh high");

        // Loads and extension
        do_op(2, B + 32'd8, '0, "R3 lw");
        for (int o = 0; o < 4; o++) begin
            do_op(0, B + 32'd8 + 32'(o), '0, "R5 lb");
            do_op(3, B + 32'd8 + 32'(o), '0, "R5 lbu");
        end
        do_op(1, B + 32'd8, '0, "R5 lh low");
        do_op(1, B + 32'd18, '0, "R5 lh high");
        do_op(4, B + 32'd18, '0, "R5 lhu high");
        do_op(4, B + 32'd10, '0, "R5 lhu");

        // Misalignment
        do_op(1, B + 32'd1, '0, "R2 lh odd");
        do_op(2, B + 32'd2, '0, "R2 lw off2");
        do_op(7, B + 32'd3, 32'hDEAD_BEEF, "R2 sw off3");
        do_op(6, B + 32'd5, 32'hDEAD_BEEF, "R2 sh odd");
        do_op(11, B + 32'd2, 32'd5, "R2 amo off2");
        do_op(8, B + 32'd1, '0, "R2 lr odd");

        // Reservation
        do_op(8, B + 32'd20, '0, "R8 lr");
        do_op(9, B + 32'd20, 32'hCAFE_0001, "R8 sc success");
        do_op(9, B + 32'd20, 32'hCAFE_0002, "R9 sc after clear");
        do_op(8, B + 32'd20, '0, "R8 lr again");
        do_op(9, B + 32'd24, 32'hCAFE_0003, "R9 sc other word");
        do_op(9, B + 32'd20, 32'hCAFE_0004, "R9 sc cleared by mismatch");
        do_op(8, B + 32'd20, '0, "R8 lr third");
        do_op(9, B + 32'd22, 32'hCAFE_0005, "R9 sc misaligned");
        do_op(9, B + 32'd20, 32'hCAFE_0006, "R9 sc cleared by misaligned");

        // Atomics, each operation with both operand signs
        for (int op = 10; op <= 18; op++) begin
            do_op(7, B + 32'd28, 32'h8000_0005, "R7 seed");
            do_op(op, B + 32'd28, 32'h7FFF_FFF0, "R7 amo positive operand");
            do_op(op, B + 32'd28, 32'hFFFF_FFFE, "R6 amo negative operand");
        end

        // Faults
        fault_idx = int'(B[7:2]) + 10;
        do_op(2, B + 32'd40, '0, "R10 lw fault");
        do_op(11, B + 32'd40, 32'd7, "R10 amo fault");
        do_op(8, B + 32'd40, '0, "R10 lr fault");
        do_op(9, B + 32'd40, 32'd9, "R10 sc after faulted lr");
        fault_idx = -1;
        do_op(11, B + 32'd40, 32'd7, "R10 amo after fault cleared");

        // Undefined codes
        do_op(19, B + 32'd44, 32'd1, "R11 code 19");
        do_op(31, B + 32'd45, 32'd1, "R11 code 31");

        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1 idle stall", {31'b0, stall}, 32'd0);
        chk("R1 idle mem_req", {31'b0, mem_req}, 32'd0);
        summary();
        $finish;
    end
endmodule